// File: doc/BRIEF.md
# Edge-Latched Interrupt Mask Controller

This block gathers a set of external interrupt lines and reduces them to a single interrupt request for a host processor. Each line is first brought into the clock domain by a short flop chain. An edge detector on the synchronised value then compares the current sample with the previous one. A strap input picks, line by line, whether a rising or a falling transition counts as an event. A detected event sets a sticky latch for that line. The latch then waits until software clears it.

The host reaches the block through a simple register port with a write strobe, an address, write data and combinational read data. Through this port the host can:

- read the synchronised line levels;
- set the mask that gates latches into the pending view;
- read the pending view;
- clear chosen latches;
- turn the global request enable on and off;
- keep an interrupt vector byte, which is also driven out steadily for use during acknowledge.

Reset clears the mask, the enable and the vector. Reset does not clear the event latches. Software therefore clears them once after power-up, before it enables interrupts.

Top module: `irq_edge_mask_top`

## Requirements
- R1: A line whose `riseSel` bit is 1 sets its latch on a 0-to-1 change only. The latch is visible in the pending register (offset 0x82) within 3 clock edges after the input changes.
- R2: A line whose `riseSel` bit is 0 sets its latch on a 1-to-0 change only. Its 0-to-1 changes are ignored.
- R3: Pending bit n reads 1 exactly when latch n is set and mask bit n is 1. The mask is read and written at offset 0x83, and reset clears it to 0.
- R4: An event latched while its mask bit is 0 is held. Setting the mask bit later, with no clear in between, makes it show as pending at once.
- R5: Writing the clear register (offset 0x84) with bit n set clears latch n only. A clear takes priority over an edge detected in the same cycle.
- R6: Neither power-on reset nor a later reset pulse clears a latch.
- R7: `irqReq` is 1 exactly when the enable bit (bit 0 of offset 0x81, reset 0) is 1 and at least one pending bit is 1.
- R8: The vector register at offset 0x85 reads back what was written, resets to 0, and is driven continuously on `vecOut`.
- R9: A read of offset 0x80 returns the synchronised input levels, two clock edges behind the pins.
- R10: For the first three clock edges after reset is released, no edge is detected, so levels already present at the pins during reset cause no event.
- R11: Reads of unmapped offsets and of the clear register return 0. A write to the pending offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | N_LINES | External interrupt lines, asynchronous |
| riseSel | input | N_LINES | Per-line edge choice: 1 rising, 0 falling |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register offset |
| wrData | input | N_LINES | Register write data |
| rdData | output | N_LINES | Register read data, combinational from `addr` |
| irqReq | output | 1 | Interrupt request to the host |
| vecOut | output | N_LINES | Stored interrupt vector |

## Verification
The bench uses the default parameters: eight lines and a two-stage synchroniser. With these values the latency from pin to pending is three edges and the priming window after reset is three edges long. The strap value 0x0F splits the lines into four rising-edge and four falling-edge lines, so one stimulus step can exercise both polarities and both ignored directions at once. The short synchroniser also makes exact timing cases practical, including a clear that meets an edge in the same cycle and inputs held high across a reset.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_RAW  = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h81;
  localparam logic [ADDR_W-1:0] OFS_PEND = 8'h82;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h83;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_VEC  = 8'h85;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_RAW,
    RD_CTRL,
    RD_PEND,
    RD_MASK,
    RD_VEC
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrClr;
    logic   wrCtrl;
    logic   wrVec;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strb
);

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_NONE;
    strb.wrMask = wrEn && (addr == OFS_MASK);
    strb.wrClr  = wrEn && (addr == OFS_CLR);
    strb.wrCtrl = wrEn && (addr == OFS_CTRL);
    strb.wrVec  = wrEn && (addr == OFS_VEC);
    case (addr)
      OFS_RAW:  strb.rdSel = RD_RAW;
      OFS_CTRL: strb.rdSel = RD_CTRL;
      OFS_PEND: strb.rdSel = RD_PEND;
      OFS_MASK: strb.rdSel = RD_MASK;
      OFS_VEC:  strb.rdSel = RD_VEC;
      default:  strb.rdSel = RD_NONE;
    endcase
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMask, strb.wrClr, strb.wrCtrl, strb.wrVec})); // R11

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strb.wrMask || strb.wrClr || strb.wrCtrl || strb.wrVec)); // R11

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  logic riseSel,
  input  logic armed,
  output logic lineSync,
  output logic edgeHit
);

  logic [SYNC_DEPTH:0] pipe;
  logic                curS;
  logic                prevS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipe <= '0;
    end else begin
      pipe[0] <= lineIn;
      for (int i = 1; i <= SYNC_DEPTH; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign curS     = pipe[SYNC_DEPTH-1];
  assign prevS    = pipe[SYNC_DEPTH];
  assign lineSync = curS;
  assign edgeHit  = armed && (riseSel ? (curS && !prevS) : (!curS && prevS));

  AST_EDGE_DIR: assert property (@(posedge clk) disable iff (!rstN)
    edgeHit |=> (prevS == riseSel)); // R1

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int N_LINES    = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_LINES-1:0] irqIn,
  input  logic [N_LINES-1:0] riseSel,
  input  logic [N_LINES-1:0] wrData,
  input  ctrlStrobes_t       strb,
  output logic [N_LINES-1:0] rdData,
  output logic               irqReq,
  output logic [N_LINES-1:0] vecOut
);

  localparam int PRIME_CYC = SYNC_DEPTH + 1;
  localparam int PRIME_W   = $clog2(PRIME_CYC + 1);
  localparam logic [PRIME_W-1:0] PRIME_DONE = PRIME_W'(PRIME_CYC);

  logic [PRIME_W-1:0] primeCnt;
  logic               armed;
  logic [N_LINES-1:0] lineSync;
  logic [N_LINES-1:0] edgeVec;
  logic [N_LINES-1:0] clrBits;
  logic [N_LINES-1:0] latchQ;
  logic [N_LINES-1:0] maskQ;
  logic [N_LINES-1:0] pending;
  logic [N_LINES-1:0] vecQ;
  logic               enQ;

  // Priming counter: hold edge detection off until the chain holds real samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      primeCnt <= '0;
    end else if (primeCnt != PRIME_DONE) begin
      primeCnt <= primeCnt + 1'b1;
    end
  end
  assign armed = (primeCnt == PRIME_DONE);

  for (genvar g = 0; g < N_LINES; g++) begin : gLine
    irq_edge_det #(.SYNC_DEPTH(SYNC_DEPTH)) uDet (
      .clk      (clk),
      .rstN     (rstN),
      .lineIn   (irqIn[g]),
      .riseSel  (riseSel[g]),
      .armed    (armed),
      .lineSync (lineSync[g]),
      .edgeHit  (edgeVec[g])
    );
  end

  assign clrBits = strb.wrClr ? wrData : '0;

  // Event latches carry no reset; only the clear register empties them
  always_ff @(posedge clk) begin
    latchQ <= (latchQ | edgeVec) & ~clrBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      enQ   <= 1'b0;
      vecQ  <= '0;
    end else begin
      if (strb.wrMask) maskQ <= wrData;
      if (strb.wrCtrl) enQ   <= wrData[0];
      if (strb.wrVec)  vecQ  <= wrData;
    end
  end

  assign pending = latchQ & maskQ;
  assign irqReq  = enQ && (|pending);
  assign vecOut  = vecQ;

  always_comb begin
    case (strb.rdSel)
      RD_RAW:  rdData = lineSync;
      RD_CTRL: rdData = {{(N_LINES-1){1'b0}}, enQ};
      RD_PEND: rdData = pending;
      RD_MASK: rdData = maskQ;
      RD_VEC:  rdData = vecQ;
      default: rdData = '0;
    endcase
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((latchQ & $past(wrData)) == '0)); // R5

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrClr |=> (($past(latchQ) & ~latchQ) == '0)); // R4

  AST_NO_EARLY_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> ((latchQ & ~$past(latchQ)) == '0)); // R10

  AST_REQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (maskQ != '0)); // R7

endmodule

// File: rtl/irq_edge_mask_top.sv
module irq_edge_mask_top
  import irq_pkg::*;
#(
  parameter int N_LINES    = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_LINES-1:0] irqIn,
  input  logic [N_LINES-1:0] riseSel,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_LINES-1:0] wrData,
  output logic [N_LINES-1:0] rdData,
  output logic               irqReq,
  output logic [N_LINES-1:0] vecOut
);

  ctrlStrobes_t strb;

  irq_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  irq_datapath #(.N_LINES(N_LINES), .SYNC_DEPTH(SYNC_DEPTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .riseSel (riseSel),
    .wrData  (wrData),
    .strb    (strb),
    .rdData  (rdData),
    .irqReq  (irqReq),
    .vecOut  (vecOut)
  );

endmodule

// File: tb/sim_irq_edge_mask_top.sv
`timescale 1ns/1ps
module sim_irq_edge_mask_top;

  localparam logic [7:0] A_RAW  = 8'h80;
  localparam logic [7:0] A_CTRL = 8'h81;
  localparam logic [7:0] A_PEND = 8'h82;
  localparam logic [7:0] A_MASK = 8'h83;
  localparam logic [7:0] A_CLR  = 8'h84;
  localparam logic [7:0] A_VEC  = 8'h85;

  // {input pattern, expected pending}, strap 0x0F, mask 0xFF, previous pattern 0x00
  localparam int NSTEP = 6;
  localparam logic [15:0] STEPS [NSTEP] = '{
    16'h0F_0F, 16'hFF_00, 16'h3C_C0, 16'hC3_33, 16'h00_C0, 16'hA5_05
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] irqIn;
  logic [7:0] riseSel = 8'h0F;
  logic       wrEn;
  logic [7:0] addr;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       irqReq;
  logic [7:0] vecOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  irq_edge_mask_top u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .riseSel(riseSel), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqReq(irqReq), .vecOut(vecOut)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqIn = 8'h0F; wrEn = 1'b0; addr = 8'h00; wrData = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // Reset state (R3 R7 R8)
    check("R7 reset irqReq", {7'd0, irqReq}, 8'h00);
    check("R8 reset vecOut", vecOut, 8'h00);
    regRead(A_MASK, rv); check("R3 reset mask", rv, 8'h00);
    regRead(A_CTRL, rv); check("R7 reset enable", rv, 8'h00);

    // R10: rising lines held high across reset give no event
    regWrite(A_CLR, 8'hFF);
    regWrite(A_MASK, 8'hFF);
    waitCyc(4);
    regRead(A_PEND, rv); check("R10 no event from levels held in reset", rv, 8'h00);
    irqIn = 8'h00;
    waitCyc(4);
    regWrite(A_CLR, 8'hFF);

    // R1 R2 R3: table walk
    for (int i = 0; i < NSTEP; i++) begin
      irqIn = STEPS[i][15:8];
      waitCyc(4);
      regRead(A_PEND, rv);
      check($sformatf("R1 R2 step %0d pending", i), rv, STEPS[i][7:0]);
      regWrite(A_CLR, 8'hFF);
    end
    irqIn = 8'h00;
    waitCyc(4);
    regWrite(A_CLR, 8'hFF);

    // R4: masked event held, released when mask set
    regWrite(A_MASK, 8'h00);
    irqIn = 8'h01;
    waitCyc(4);
    regRead(A_PEND, rv); check("R4 masked event hidden", rv, 8'h00);
    regWrite(A_MASK, 8'h01);
    regRead(A_PEND, rv); check("R4 event released by mask", rv, 8'h01);

    // R7: request gating
    check("R7 enable off", {7'd0, irqReq}, 8'h00);
    regWrite(A_CTRL, 8'h01);
    check("R7 enable on", {7'd0, irqReq}, 8'h01);
    regWrite(A_MASK, 8'h00);
    check("R7 nothing pending", {7'd0, irqReq}, 8'h00);
    regWrite(A_MASK, 8'hFF);
    check("R7 pending again", {7'd0, irqReq}, 8'h01);
    regWrite(A_CTRL, 8'h00);
    check("R7 enable cleared", {7'd0, irqReq}, 8'h00);

    // R5: selective clear, then clear meeting an edge
    irqIn = 8'h03;
    waitCyc(4);
    regRead(A_PEND, rv); check("R5 two latched", rv, 8'h03);
    regWrite(A_CLR, 8'h01);
    regRead(A_PEND, rv); check("R5 only bit 0 cleared", rv, 8'h02);
    irqIn = 8'h07;
    repeat (2) @(posedge clk);
    @(negedge clk);
    regWrite(A_CLR, 8'h04);
    waitCyc(2);
    regRead(A_PEND, rv); check("R5 clear beats same-cycle edge", rv, 8'h02);

    // R6: reset pulse keeps latches
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    regRead(A_MASK, rv); check("R3 mask cleared by reset", rv, 8'h00);
    regRead(A_PEND, rv); check("R3 pending hidden after reset", rv, 8'h00);
    regWrite(A_MASK, 8'hFF);
    waitCyc(5);
    regRead(A_PEND, rv); check("R6 latch survives reset", rv, 8'h02);

    // R8: vector
    regWrite(A_VEC, 8'h5A);
    regRead(A_VEC, rv); check("R8 vector readback", rv, 8'h5A);
    check("R8 vecOut", vecOut, 8'h5A);

    // R9: raw read
    irqIn = 8'h96;
    waitCyc(3);
    regRead(A_RAW, rv); check("R9 raw levels", rv, 8'h96);

    // R11: unmapped and read-only
    regWrite(A_CLR, 8'hFF);
    regRead(A_PEND, rv); check("R11 pending cleared", rv, 8'h00);
    regWrite(A_PEND, 8'hFF);
    regRead(A_PEND, rv); check("R11 pending write ignored", rv, 8'h00);
    regRead(8'h90, rv); check("R11 unmapped read", rv, 8'h00);
    regRead(A_CLR, rv); check("R11 clear reads zero", rv, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule